// File: doc/BRIEF.md
# Pixel Input Formatter with OSD Insertion

This block turns the encoder's raw pixel input into a single per-pixel Y/U/V stream for the chroma and luma stages that follow. It accepts three kinds of input: 24-bit RGB on three 8-bit buses, 16-bit 4:2:2 YUV with luma on one bus and time-multiplexed U/V samples on another, or a 3-bit on-screen-display colour that replaces the video during active picture time. RGB values are not converted here. They are forwarded unchanged on the Y/U/V outputs and marked with an RGB tag, so an upstream or downstream matrix can process them.

A fourth mode serves a DAC bypass path. Each colour channel is widened to 9 bits by placing that channel's OSD bit below the 8 data bits. The results are presented on three bypass words.

The block works in the internal pixel-clock domain. A clock enable marks each pixel slot, so the same logic covers both the single-rate and the doubled input clock. The negative-going horizontal sync sets the 4:2:2 chroma phase. An active-video input gates both the OSD override and the valid flag.

Top module: `pixel_fmt_osd`

## Requirements
- R1: With mode code 00 (RGB) and no OSD, `y_out`, `u_out` and `v_out` carry `r_in`, `g_in` and `b_in`, and `out_is_rgb` is high whenever `out_valid` is high. `out_is_rgb` is never high in any other case.
- R2: With mode code 01 (YUV 4:2:2), luma comes from `g_in` and chroma from `b_in`. The first sample at or after a falling edge of `hsync_n` is phase 0 and phases then alternate. With `uv_swap` low, phase 0 carries U and phase 1 carries V. The U and V of a pair are output with both luma samples of that pair.
- R3: With `uv_swap` high, phase 0 carries V and phase 1 carries U. Luma handling is unchanged.
- R4: When `osd_en` and `vid_active` are both high in mode 00 or 01, `osd_rgb` {R,G,B} replaces the video with these Y/U/V values (hex): 000 10/80/80, 001 28/F1/6D, 010 90/36/22, 011 A9/A5/10, 100 51/5A/F0, 101 6A/C9/DD, 110 D2/0E/92, 111 EB/80/80.
- R5: With `vid_active` low, `osd_en` has no effect, and the video data reaches the outputs.
- R6: In every mode, `thru_y` is {`r_in`, `osd_rgb[2]`}, `thru_comp` is {`g_in`, `osd_rgb[1]`} and `thru_chroma` is {`b_in`, `osd_rgb[0]`}, with the OSD bit in bit 0.
- R7: An input captured at one `pix_en` cycle appears at the outputs after the next `pix_en` cycle. While `pix_en` is low, every output holds its value.
- R8: `out_valid` is high only for samples captured with `vid_active` high in mode 00 or 01. It stays low in mode 11 (bypass) and in the unused code 10.
- R9: After reset, all data outputs are zero and `out_valid` and `out_is_rgb` are low.
- R10: A falling edge of `hsync_n` in the middle of a pair restarts at phase 0. The unpaired chroma sample is discarded, and the last complete pair stays applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Internal pixel clock |
| rst_n | input | 1 | Active-low synchronous reset |
| pix_en | input | 1 | Pixel slot enable |
| hsync_n | input | 1 | Horizontal sync, active low |
| vid_active | input | 1 | High during active picture |
| in_mode | input | 2 | 00 RGB, 01 YUV 4:2:2, 11 DAC bypass, 10 unused |
| r_in | input | DW | Red data |
| g_in | input | DW | Green data or luma |
| b_in | input | DW | Blue data or multiplexed U/V |
| osd_en | input | 1 | OSD override enable |
| osd_rgb | input | 3 | OSD colour {R,G,B} |
| uv_swap | input | 1 | Reverse U/V phase order |
| y_out | output | DW | Luma, or red in RGB mode |
| u_out | output | DW | U, or green in RGB mode |
| v_out | output | DW | V, or blue in RGB mode |
| out_valid | output | 1 | Output sample is active video |
| out_is_rgb | output | 1 | Output sample is untransformed RGB |
| thru_y | output | DW+1 | Bypass word for the luma DAC |
| thru_comp | output | DW+1 | Bypass word for the composite DAC |
| thru_chroma | output | DW+1 | Bypass word for the chroma DAC |

## Verification
Internal state that matters here is the chroma phase bit, its held U/V pair and the previous sync level. If the phase is wrong, U and V values trade places on the outputs as soon as the first pair after a sync edge is emitted. If the held pair is lost or stale, the second luma sample of a pair carries chroma that does not match the first, one pixel later. If the sync history is wrong, the mid-pair restart breaks: a discarded chroma sample shows up within two pixel slots.

// File: rtl/pixel_fmt_osd.sv
module pixel_fmt_osd #(
  parameter int DW = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          pix_en,
  input  logic          hsync_n,
  input  logic          vid_active,
  input  logic [1:0]    in_mode,
  input  logic [DW-1:0] r_in,
  input  logic [DW-1:0] g_in,
  input  logic [DW-1:0] b_in,
  input  logic          osd_en,
  input  logic [2:0]    osd_rgb,
  input  logic          uv_swap,
  output logic [DW-1:0] y_out,
  output logic [DW-1:0] u_out,
  output logic [DW-1:0] v_out,
  output logic          out_valid,
  output logic          out_is_rgb,
  output logic [DW:0]   thru_y,
  output logic [DW:0]   thru_comp,
  output logic [DW:0]   thru_chroma
);
  localparam int SH = DW - 8;

  function automatic logic [23:0] palette(input logic [2:0] c);
    case (c)
      3'b000:  palette = 24'h10_80_80;
      3'b001:  palette = 24'h28_F1_6D;
      3'b010:  palette = 24'h90_36_22;
      3'b011:  palette = 24'hA9_A5_10;
      3'b100:  palette = 24'h51_5A_F0;
      3'b101:  palette = 24'h6A_C9_DD;
      3'b110:  palette = 24'hD2_0E_92;
      default: palette = 24'hEB_80_80;
    endcase
  endfunction

  logic          hs_d, ph_q;
  logic [1:0]    s_mode;
  logic          s_act, s_osd;
  logic [2:0]    s_osdc;
  logic [DW-1:0] s_r, s_g, s_b;
  logic [DW-1:0] hold_u, hold_v;

  wire hs_fall = hs_d & ~hsync_n;
  wire ph_cur  = hs_fall ? 1'b0 : ~ph_q;

  logic [DW-1:0] pu, pv;
  always_comb begin
    if (ph_cur) begin
      pu = uv_swap ? b_in : s_b;
      pv = uv_swap ? s_b  : b_in;
    end else begin
      pu = hold_u;
      pv = hold_v;
    end
  end

  wire        use_osd = s_osd & ~s_mode[1];
  wire [23:0] pal     = palette(s_osdc);
  wire [DW-1:0] pal_y = DW'(pal[23:16]) << SH;
  wire [DW-1:0] pal_u = DW'(pal[15:8])  << SH;
  wire [DW-1:0] pal_v = DW'(pal[7:0])   << SH;
  wire        is_yuv  = (s_mode == 2'b01);

  wire [DW-1:0] nx_y = use_osd ? pal_y : (is_yuv ? s_g : s_r);
  wire [DW-1:0] nx_u = use_osd ? pal_u : (is_yuv ? pu  : s_g);
  wire [DW-1:0] nx_v = use_osd ? pal_v : (is_yuv ? pv  : s_b);
  wire          nx_valid = s_act & ~s_mode[1];

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      hs_d <= 1'b1;  ph_q <= 1'b1;
      s_mode <= '0;  s_act <= 1'b0;  s_osd <= 1'b0;  s_osdc <= '0;
      s_r <= '0;  s_g <= '0;  s_b <= '0;
      hold_u <= '0;  hold_v <= '0;
      y_out <= '0;  u_out <= '0;  v_out <= '0;
      out_valid <= 1'b0;  out_is_rgb <= 1'b0;
      thru_y <= '0;  thru_comp <= '0;  thru_chroma <= '0;
    end else if (pix_en) begin
      hs_d   <= hsync_n;
      ph_q   <= ph_cur;
      s_mode <= in_mode;
      s_act  <= vid_active;
      s_osd  <= osd_en & vid_active;
      s_osdc <= osd_rgb;
      s_r <= r_in;  s_g <= g_in;  s_b <= b_in;
      if (ph_cur) begin
        hold_u <= pu;
        hold_v <= pv;
      end
      y_out <= nx_y;  u_out <= nx_u;  v_out <= nx_v;
      out_valid   <= nx_valid;
      out_is_rgb  <= nx_valid & (s_mode == 2'b00) & ~use_osd;
      thru_y      <= {s_r, s_osdc[2]};
      thru_comp   <= {s_g, s_osdc[1]};
      thru_chroma <= {s_b, s_osdc[0]};
    end
  end
endmodule

// File: rtl/pixel_fmt_osd_chk.sv
module pixel_fmt_osd_chk #(
  parameter int DW = 8
) (
  input logic          clk,
  input logic          rst_n,
  input logic          pix_en,
  input logic          vid_active,
  input logic [1:0]    in_mode,
  input logic          osd_en,
  input logic [2:0]    osd_rgb,
  input logic [DW-1:0] y_out,
  input logic [DW-1:0] u_out,
  input logic [DW-1:0] v_out,
  input logic          out_valid,
  input logic          out_is_rgb,
  input logic [DW:0]   thru_y,
  input logic [DW:0]   thru_comp,
  input logic [DW:0]   thru_chroma
);
  logic [1:0] m1, m2;
  logic       a1, a2, e1, e2;
  logic [2:0] o1, o2;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      m1 <= '0; m2 <= '0; a1 <= 1'b0; a2 <= 1'b0;
      e1 <= 1'b0; e2 <= 1'b0; o1 <= '0; o2 <= '0;
    end else if (pix_en) begin
      m1 <= in_mode; m2 <= m1;
      a1 <= vid_active; a2 <= a1;
      e1 <= osd_en; e2 <= e1;
      o1 <= osd_rgb; o2 <= o1;
    end
  end

  AST_RGB_TAG: assert property (@(posedge clk) disable iff (!rst_n)
    out_is_rgb |-> (out_valid && m2 == 2'b00));  // R1

  AST_OSD_BLACK: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && e2 && a2 && o2 == 3'b000) |->
      (y_out[DW-1 -: 8] == 8'h10 && u_out[DW-1 -: 8] == 8'h80 && v_out[DW-1 -: 8] == 8'h80));  // R4

  AST_THRU_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (thru_y[0] == o2[2] && thru_comp[0] == o2[1] && thru_chroma[0] == o2[0]));  // R6

  AST_HOLD_NO_EN: assert property (@(posedge clk) disable iff (!rst_n)
    !pix_en |=> ($stable(y_out) && $stable(u_out) && $stable(v_out) && $stable(out_valid)));  // R7

  AST_VALID_ACTIVE: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> (a2 && !m2[1]));  // R8
endmodule

bind pixel_fmt_osd pixel_fmt_osd_chk #(.DW(DW)) u_chk (.*);

// File: tb/tb_pixel_fmt_osd.sv
module tb_pixel_fmt_osd;
  localparam int P = 10;
  localparam int DW = 8;

  logic clk = 1'b0;
  always #(P/2) clk = ~clk;

  logic rst_n, pix_en, hsync_n, vid_active, osd_en, uv_swap;
  logic [1:0] in_mode;
  logic [2:0] osd_rgb;
  logic [7:0] r_in, g_in, b_in;
  logic [7:0] y_out, u_out, v_out;
  logic out_valid, out_is_rgb;
  logic [8:0] thru_y, thru_comp, thru_chroma;

  pixel_fmt_osd #(.DW(DW)) dut (.*);

  int checks = 0, errors = 0;
  bit done = 0;

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    #(P/4);
  endtask

  // mode act osden osd r g b | y u v valid rgb
  localparam int NV = 14;
  localparam logic [56:0] VEC [NV] = '{
    {2'b00,1'b1,1'b0,3'b000,8'h12,8'h34,8'h56, 8'h12,8'h34,8'h56,1'b1,1'b1},
    {2'b00,1'b0,1'b0,3'b000,8'hAA,8'hBB,8'hCC, 8'hAA,8'hBB,8'hCC,1'b0,1'b0},
    {2'b00,1'b1,1'b1,3'b000,8'h01,8'h02,8'h03, 8'h10,8'h80,8'h80,1'b1,1'b0},
    {2'b00,1'b1,1'b1,3'b001,8'h01,8'h02,8'h03, 8'h28,8'hF1,8'h6D,1'b1,1'b0},
    {2'b00,1'b1,1'b1,3'b010,8'h01,8'h02,8'h03, 8'h90,8'h36,8'h22,1'b1,1'b0},
    {2'b00,1'b1,1'b1,3'b011,8'h01,8'h02,8'h03, 8'hA9,8'hA5,8'h10,1'b1,1'b0},
    {2'b00,1'b1,1'b1,3'b100,8'h01,8'h02,8'h03, 8'h51,8'h5A,8'hF0,1'b1,1'b0},
    {2'b00,1'b1,1'b1,3'b101,8'h01,8'h02,8'h03, 8'h6A,8'hC9,8'hDD,1'b1,1'b0},
    {2'b00,1'b1,1'b1,3'b110,8'h01,8'h02,8'h03, 8'hD2,8'h0E,8'h92,1'b1,1'b0},
    {2'b00,1'b1,1'b1,3'b111,8'h01,8'h02,8'h03, 8'hEB,8'h80,8'h80,1'b1,1'b0},
    {2'b00,1'b0,1'b1,3'b111,8'h01,8'h02,8'h03, 8'h01,8'h02,8'h03,1'b0,1'b0},
    {2'b11,1'b1,1'b0,3'b101,8'h80,8'h7F,8'h01, 8'h80,8'h7F,8'h01,1'b0,1'b0},
    {2'b10,1'b1,1'b0,3'b010,8'h44,8'h55,8'h66, 8'h44,8'h55,8'h66,1'b0,1'b0},
    {2'b01,1'b1,1'b1,3'b011,8'h44,8'h55,8'h66, 8'hA9,8'hA5,8'h10,1'b1,1'b0}
  };

  task automatic yuv_step(input logic hs, input logic [7:0] yy, input logic [7:0] cc);
    hsync_n = hs; g_in = yy; b_in = cc;
    tick();
  endtask

  task automatic chk_yuv(input string tag, input logic [7:0] ey, input logic [7:0] eu, input logic [7:0] ev);
    chk(y_out == ey, {tag, " y"}, y_out, ey);
    chk(u_out == eu, {tag, " u"}, u_out, eu);
    chk(v_out == ev, {tag, " v"}, v_out, ev);
  endtask

  initial begin
    #(P*100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=0 expected=1");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    rst_n = 0; pix_en = 1; hsync_n = 1; vid_active = 0; osd_en = 0; uv_swap = 0;
    in_mode = 2'b00; osd_rgb = 3'b000; r_in = 8'h5A; g_in = 8'hA5; b_in = 8'h3C;
    repeat (3) tick();
    // R9 reset state
    chk(y_out == 0 && u_out == 0 && v_out == 0, "R9 data", {y_out, u_out, v_out}, 0);
    chk(!out_valid && !out_is_rgb, "R9 flags", {out_valid, out_is_rgb}, 0);
    chk(thru_y == 0 && thru_comp == 0 && thru_chroma == 0, "R9 thru", thru_y, 0);
    rst_n = 1;

    // Table walk: R1 R4 R5 R6 R8
    for (int i = 0; i < NV; i++) begin
      logic [56:0] v;
      v = VEC[i];
      {in_mode, vid_active, osd_en, osd_rgb, r_in, g_in, b_in} = v[56:26];
      tick(); tick();
      chk(y_out == v[25:18], $sformatf("R1/R4/R5 y vec%0d", i), y_out, v[25:18]);
      chk(u_out == v[17:10], $sformatf("R1/R4/R5 u vec%0d", i), u_out, v[17:10]);
      chk(v_out == v[9:2],   $sformatf("R1/R4/R5 v vec%0d", i), v_out, v[9:2]);
      chk(out_valid == v[1], $sformatf("R8 valid vec%0d", i), out_valid, v[1]);
      chk(out_is_rgb == v[0], $sformatf("R1 tag vec%0d", i), out_is_rgb, v[0]);
      chk(thru_y == {r_in, osd_rgb[2]} && thru_comp == {g_in, osd_rgb[1]} &&
          thru_chroma == {b_in, osd_rgb[0]}, $sformatf("R6 thru vec%0d", i),
          thru_y, {r_in, osd_rgb[2]});
    end

    // R2 YUV de-interleave
    in_mode = 2'b01; osd_en = 0; vid_active = 1; uv_swap = 0;
    yuv_step(1, 8'h00, 8'h00);
    yuv_step(0, 8'h11, 8'h21);
    yuv_step(1, 8'h12, 8'h31); chk_yuv("R2 Y1", 8'h11, 8'h21, 8'h31);
    yuv_step(1, 8'h13, 8'h23); chk_yuv("R2 Y2", 8'h12, 8'h21, 8'h31);
    yuv_step(1, 8'h14, 8'h33); chk_yuv("R2 Y3", 8'h13, 8'h23, 8'h33);
    yuv_step(1, 8'h15, 8'h25); chk_yuv("R2 Y4", 8'h14, 8'h23, 8'h33);

    // R3 swapped order
    uv_swap = 1;
    yuv_step(1, 8'h00, 8'h00);
    yuv_step(0, 8'h61, 8'h71);
    yuv_step(1, 8'h62, 8'h81); chk_yuv("R3 Y1", 8'h61, 8'h81, 8'h71);
    yuv_step(1, 8'h63, 8'h73); chk_yuv("R3 Y2", 8'h62, 8'h81, 8'h71);
    uv_swap = 0;

    // R10 mid-pair restart
    yuv_step(1, 8'h00, 8'h00);
    yuv_step(0, 8'h40, 8'h50);
    yuv_step(1, 8'h41, 8'h51); chk_yuv("R10 a", 8'h40, 8'h50, 8'h51);
    yuv_step(1, 8'h42, 8'h52); chk_yuv("R10 b", 8'h41, 8'h50, 8'h51);
    yuv_step(0, 8'h43, 8'h53); chk_yuv("R10 c", 8'h42, 8'h50, 8'h51);
    yuv_step(0, 8'h44, 8'h54); chk_yuv("R10 d", 8'h43, 8'h53, 8'h54);

    // R7 latency and stall
    in_mode = 2'b00; hsync_n = 1; r_in = 8'hC1; g_in = 8'hC2; b_in = 8'hC3;
    tick();
    chk(y_out != 8'hC1, "R7 one-slot latency", y_out, 8'hC1);
    tick();
    chk(y_out == 8'hC1, "R7 two-slot arrival", y_out, 8'hC1);
    pix_en = 0; r_in = 8'hD1; g_in = 8'hD2; b_in = 8'hD3; vid_active = 0;
    repeat (3) tick();
    chk(y_out == 8'hC1 && u_out == 8'hC2 && v_out == 8'hC3 && out_valid,
        "R7 hold", y_out, 8'hC1);
    pix_en = 1;
    tick(); tick();
    chk(y_out == 8'hD1 && !out_valid, "R7 resume", y_out, 8'hD1);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule